// File: doc/BRIEF.md
# Pipeline Operand Bypass

This block sits at the operand-capture point of a five-stage integer pipeline and supplies the left and right ALU operands for the instruction in stage 2. It also supplies the base operand for data-memory addressing. An instruction's result exists only in pipeline registers for three cycles before the register file holds it. These are the ALU result register, the memory-stage register and the write-back register. During that window, any younger instruction that names the same register must take the value from the newest of those registers and not from the register-file read port.

The block keeps its own shifted copy of each in-flight instruction's destination register number and write flag. It compares both source numbers against the three result stages and steers either a result register or the register-file read data into the operand latches. An immediate can replace the right operand. The data address is the sum of the latched left operand and the sign-extended immediate. That sum is combinational, so it is valid during stage 3 while a store drives its write strobe. The ALU, the memory and the decoder are outside the block. The decoder must not issue an instruction that reads the destination of the instruction directly ahead of it, because that result is still inside the ALU.

Top module: `opnd_bypass`

## Requirements
- R1: Driving `rst_n` low clears `alu_l`, `alu_r` and `dmem_addr` to zero at once, without waiting for a clock edge, and clears every in-flight write flag. Release takes effect on the second rising edge after `rst_n` returns high.
- R2: The operands chosen for the instruction presented in a cycle appear on `alu_l` and `alu_r` after the next rising edge.
- R3: A source that matches the destination of a writing instruction issued two slots earlier is taken from `res_a`.
- R4: A source that matches a writing instruction issued three slots earlier, and that has no newer match, is taken from `res_n`.
- R5: A source that matches a writing instruction issued four slots earlier, and that has no newer match, is taken from `res_r`.
- R6: A source with no match in the three result stages, including one written five or more slots earlier, is taken from the register-file read data.
- R7: When several in-flight stages target the same source, the youngest producer wins, with priority `res_a`, then `res_n`, then `res_r`.
- R8: Source register 0 always yields zero. This holds whatever the read data is, and even when an in-flight instruction writes register 0 with its write flag set.
- R9: An in-flight instruction whose write flag was clear at issue never supplies a forwarded value, even when its destination number matches.
- R10: With `iss_use_imm` set, `alu_r` receives `iss_imm` zero-extended. The left operand is still selected from its source.
- R11: `dmem_addr` equals `alu_l` plus the sign-extended `iss_imm` of the same instruction, with no further clock delay.
- R12: The left and right selections are made independently. Two sources of one instruction can come from different stages, and one register named on both sides gives the same value on both sides.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released through two flops |
| iss_src_l | input | 5 | Left source register number of the stage-2 instruction |
| iss_src_r | input | 5 | Right source register number of the stage-2 instruction |
| iss_dst | input | 5 | Destination register number of the stage-2 instruction |
| iss_wen | input | 1 | Stage-2 instruction will write its destination |
| iss_use_imm | input | 1 | Right operand is the zero-extended immediate |
| iss_imm | input | 16 | Immediate field; also the address offset |
| rf_rdata_l | input | 32 | Register-file read data for the left source |
| rf_rdata_r | input | 32 | Register-file read data for the right source |
| res_a | input | 32 | ALU result register (producer two slots ahead) |
| res_n | input | 32 | Memory-stage result register (three slots ahead) |
| res_r | input | 32 | Write-back result register (four slots ahead) |
| alu_l | output | 32 | Latched left ALU operand |
| alu_r | output | 32 | Latched right ALU operand |
| dmem_addr | output | 32 | Combinational data-memory address |

## Verification
Every cycle, the assertions check the stage-selection rules. Register 0 never matches. A stage whose write flag is clear never wins the first slot. A match in the youngest stage always wins. An immediate lands zero-extended on the right operand, and a zero base gives exactly the sign-extended offset as the address. Only the bench's instruction sequences can show that values from the correct producer arrive. The bench runs a model of the datapath and register file and compares each operand and address against a sequential, in-order reference. That comparison covers the distance-to-stage mapping, the priority among stale and fresh writers of one register, and the asynchronous clear in the middle of a run.

// File: rtl/opnd_bypass_pkg.sv
package opnd_bypass_pkg;

  // Number of in-flight result registers that can be bypassed.
  localparam int RES_STAGES = 3;

  // Operand source choice; numeric value n > 0 means result stage n-1.
  typedef enum logic [1:0] {
    SRC_RF    = 2'd0,
    SRC_RES_A = 2'd1,
    SRC_RES_N = 2'd2,
    SRC_RES_R = 2'd3
  } byp_src_e;

endpackage

// File: rtl/byp_rst_sync.sv
module byp_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);

  logic meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q  <= 1'b0;
      rst_q_n <= 1'b0;
    end else begin
      meta_q  <= 1'b1;
      rst_q_n <= meta_q;
    end
  end

endmodule

// File: rtl/byp_tag_chain.sv
module byp_tag_chain #(
  parameter int REG_AW = 5,
  parameter int DEPTH  = 4
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [REG_AW-1:0]                iss_dst,
  input  logic                             iss_wen,
  output logic [DEPTH-2:0][REG_AW-1:0]     fwd_dst,
  output logic [DEPTH-2:0]                 fwd_wen
);

  // Slot 0 tracks the instruction in the ALU stage; slots 1.. track the
  // instructions whose results sit in the bypassable result registers.
  logic [DEPTH-1:0][REG_AW-1:0] dst_d, dst_q;
  logic [DEPTH-1:0]             wen_d, wen_q;

  always_comb begin
    dst_d[0] = iss_dst;
    wen_d[0] = iss_wen;
  end

  for (genvar s = 1; s < DEPTH; s++) begin : g_shift
    always_comb begin
      dst_d[s] = dst_q[s-1];
      wen_d[s] = wen_q[s-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dst_q <= '0;
      wen_q <= '0;
    end else begin
      dst_q <= dst_d;
      wen_q <= wen_d;
    end
  end

  assign fwd_dst = dst_q[DEPTH-1:1];
  assign fwd_wen = wen_q[DEPTH-1:1];

  AST_FLAG_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n)
    iss_wen |=> wen_q[0]); // R9

endmodule

// File: rtl/byp_match.sv
module byp_match
  import opnd_bypass_pkg::*;
#(
  parameter int REG_AW = 5
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic [REG_AW-1:0]                  src,
  input  logic [RES_STAGES-1:0][REG_AW-1:0]  fwd_dst,
  input  logic [RES_STAGES-1:0]              fwd_wen,
  output byp_src_e                           sel,
  output logic                               src_live
);

  logic [RES_STAGES-1:0] hit;

  assign src_live = |src;

  for (genvar s = 0; s < RES_STAGES; s++) begin : g_cmp
    assign hit[s] = fwd_wen[s] && (fwd_dst[s] == src) && src_live;
  end

  // Oldest first so the youngest hit overwrites.
  always_comb begin
    sel = SRC_RF;
    for (int i = RES_STAGES - 1; i >= 0; i--) begin
      if (hit[i]) sel = byp_src_e'(2'(i + 1));
    end
  end

  AST_ZERO_NO_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (src == '0) |-> (sel == SRC_RF && !src_live)); // R8

  AST_IDLE_STAGE_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
    !fwd_wen[0] |-> (sel != SRC_RES_A)); // R9

  AST_YOUNGEST_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_wen[0] && fwd_dst[0] == src && src != '0) |-> (sel == SRC_RES_A)); // R7

endmodule

// File: rtl/byp_mux.sv
module byp_mux
  import opnd_bypass_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  byp_src_e                           sel,
  input  logic                               src_live,
  input  logic [DATA_W-1:0]                  rf_data,
  input  logic [RES_STAGES-1:0][DATA_W-1:0]  res,
  output logic [DATA_W-1:0]                  value
);

  always_comb begin
    unique case (sel)
      SRC_RES_A: value = res[0];
      SRC_RES_N: value = res[1];
      SRC_RES_R: value = res[2];
      default:   value = rf_data;
    endcase
    if (!src_live) value = '0;
  end

endmodule

// File: rtl/opnd_bypass.sv
module opnd_bypass
  import opnd_bypass_pkg::*;
#(
  parameter  int DATA_W   = 32,
  parameter  int NUM_REGS = 32,
  parameter  int IMM_W    = 16,
  localparam int REG_AW   = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [REG_AW-1:0] iss_src_l,
  input  logic [REG_AW-1:0] iss_src_r,
  input  logic [REG_AW-1:0] iss_dst,
  input  logic              iss_wen,
  input  logic              iss_use_imm,
  input  logic [IMM_W-1:0]  iss_imm,
  input  logic [DATA_W-1:0] rf_rdata_l,
  input  logic [DATA_W-1:0] rf_rdata_r,
  input  logic [DATA_W-1:0] res_a,
  input  logic [DATA_W-1:0] res_n,
  input  logic [DATA_W-1:0] res_r,
  output logic [DATA_W-1:0] alu_l,
  output logic [DATA_W-1:0] alu_r,
  output logic [DATA_W-1:0] dmem_addr
);

  localparam int TAG_DEPTH = RES_STAGES + 1;
  localparam int EXT_W     = DATA_W - IMM_W;
  localparam int N_OPND    = 2;

  logic rst_q_n;

  byp_rst_sync u_rst_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_q_n (rst_q_n)
  );

  logic [RES_STAGES-1:0][REG_AW-1:0] fwd_dst;
  logic [RES_STAGES-1:0]             fwd_wen;

  byp_tag_chain #(
    .REG_AW (REG_AW),
    .DEPTH  (TAG_DEPTH)
  ) u_tags (
    .clk     (clk),
    .rst_n   (rst_q_n),
    .iss_dst (iss_dst),
    .iss_wen (iss_wen),
    .fwd_dst (fwd_dst),
    .fwd_wen (fwd_wen)
  );

  logic [RES_STAGES-1:0][DATA_W-1:0] res_bus;
  logic [N_OPND-1:0][REG_AW-1:0]     src_v;
  logic [N_OPND-1:0][DATA_W-1:0]     rf_v;
  logic [N_OPND-1:0][DATA_W-1:0]     fwd_v;
  logic [N_OPND-1:0]                 live_v;
  byp_src_e                          sel_v [N_OPND];

  assign res_bus = {res_r, res_n, res_a};
  assign src_v   = {iss_src_r, iss_src_l};
  assign rf_v    = {rf_rdata_r, rf_rdata_l};

  for (genvar g = 0; g < N_OPND; g++) begin : g_opnd
    byp_match #(
      .REG_AW (REG_AW)
    ) u_match (
      .clk      (clk),
      .rst_n    (rst_q_n),
      .src      (src_v[g]),
      .fwd_dst  (fwd_dst),
      .fwd_wen  (fwd_wen),
      .sel      (sel_v[g]),
      .src_live (live_v[g])
    );

    byp_mux #(
      .DATA_W (DATA_W)
    ) u_mux (
      .sel      (sel_v[g]),
      .src_live (live_v[g]),
      .rf_data  (rf_v[g]),
      .res      (res_bus),
      .value    (fwd_v[g])
    );
  end

  // Operand latch next state
  logic [DATA_W-1:0] opl_d, opr_d, off_d;
  logic [DATA_W-1:0] opl_q, opr_q, off_q;

  always_comb begin
    opl_d = fwd_v[0];
    opr_d = iss_use_imm ? {{EXT_W{1'b0}}, iss_imm} : fwd_v[1];
    off_d = {{EXT_W{iss_imm[IMM_W-1]}}, iss_imm};
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      opl_q <= '0;
      opr_q <= '0;
      off_q <= '0;
    end else begin
      opl_q <= opl_d;
      opr_q <= opr_d;
      off_q <= off_d;
    end
  end

  assign alu_l     = opl_q;
  assign alu_r     = opr_q;
  assign dmem_addr = opl_q + off_q;

  AST_IMM_ZEXT: assert property (@(posedge clk) disable iff (!rst_q_n)
    iss_use_imm |=> (alu_r == {{EXT_W{1'b0}}, $past(iss_imm)})); // R10

  AST_ZERO_BASE: assert property (@(posedge clk) disable iff (!rst_q_n)
    (iss_src_l == '0) |=> (dmem_addr == {{EXT_W{$past(iss_imm[IMM_W-1])}}, $past(iss_imm)})); // R11

  AST_LEFT_ZERO: assert property (@(posedge clk) disable iff (!rst_q_n)
    (iss_src_l == '0) |=> (alu_l == '0)); // R8

endmodule

// File: tb/test_opnd_bypass.sv
module test_opnd_bypass;

  localparam int DW = 32;
  localparam int NR = 32;
  localparam int AW = 5;
  localparam int IW = 16;
  localparam int NPROG = 21;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] iss_src_l, iss_src_r, iss_dst;
  logic          iss_wen, iss_use_imm;
  logic [IW-1:0] iss_imm;
  logic [DW-1:0] rf_rdata_l, rf_rdata_r, res_a, res_n, res_r;
  logic [DW-1:0] alu_l, alu_r, dmem_addr;

  always #4 clk = ~clk;

  opnd_bypass i_opnd_bypass (
    .clk(clk), .rst_n(rst_n),
    .iss_src_l(iss_src_l), .iss_src_r(iss_src_r), .iss_dst(iss_dst),
    .iss_wen(iss_wen), .iss_use_imm(iss_use_imm), .iss_imm(iss_imm),
    .rf_rdata_l(rf_rdata_l), .rf_rdata_r(rf_rdata_r),
    .res_a(res_a), .res_n(res_n), .res_r(res_r),
    .alu_l(alu_l), .alu_r(alu_r), .dmem_addr(dmem_addr)
  );

  // Datapath model: OR ALU, three result registers, register file.
  logic [DW-1:0] rf_mem [NR];
  logic [DW-1:0] a_q, n_q, r_q;
  logic [AW-1:0] sd [4];
  logic          sw [4];

  assign rf_rdata_l = rf_mem[iss_src_l];
  assign rf_rdata_r = rf_mem[iss_src_r];
  assign res_a = a_q;
  assign res_n = n_q;
  assign res_r = r_q;

  always @(posedge clk) begin
    a_q <= alu_l | alu_r;
    n_q <= a_q;
    r_q <= n_q;
    if (sw[3] && sd[3] != '0) rf_mem[sd[3]] <= r_q;
  end

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) begin sw[i] <= 1'b0; sd[i] <= '0; end
    end else begin
      sw[0] <= iss_wen; sd[0] <= iss_dst;
      for (int i = 1; i < 4; i++) begin sw[i] <= sw[i-1]; sd[i] <= sd[i-1]; end
    end
  end

  // Program: {wen, dst, src_l, src_r, use_imm, imm}
  localparam logic [32:0] PROG [NPROG] = '{
    {1'b1, 5'd5,  5'd0,  5'd0,  1'b1, 16'h1234},
    {1'b1, 5'd6,  5'd0,  5'd0,  1'b1, 16'h00F0},
    {1'b1, 5'd7,  5'd5,  5'd0,  1'b1, 16'h8000},
    {1'b1, 5'd8,  5'd5,  5'd6,  1'b0, 16'h0000},
    {1'b0, 5'd9,  5'd5,  5'd7,  1'b0, 16'h0010},
    {1'b1, 5'd10, 5'd1,  5'd8,  1'b0, 16'h0000},
    {1'b1, 5'd11, 5'd9,  5'd3,  1'b0, 16'hFFFC},
    {1'b1, 5'd5,  5'd2,  5'd0,  1'b1, 16'h0001},
    {1'b1, 5'd12, 5'd4,  5'd0,  1'b1, 16'h0002},
    {1'b1, 5'd5,  5'd3,  5'd0,  1'b1, 16'h0040},
    {1'b1, 5'd13, 5'd0,  5'd0,  1'b1, 16'h0000},
    {1'b1, 5'd14, 5'd5,  5'd5,  1'b0, 16'h0000},
    {1'b1, 5'd6,  5'd1,  5'd0,  1'b1, 16'h0003},
    {1'b1, 5'd6,  5'd2,  5'd0,  1'b1, 16'h0005},
    {1'b1, 5'd15, 5'd0,  5'd0,  1'b1, 16'h7777},
    {1'b1, 5'd17, 5'd0,  5'd0,  1'b1, 16'h0001},
    {1'b1, 5'd16, 5'd6,  5'd14, 1'b0, 16'h0000},
    {1'b1, 5'd0,  5'd3,  5'd1,  1'b0, 16'h0000},
    {1'b1, 5'd18, 5'd0,  5'd0,  1'b1, 16'h0AAA},
    {1'b1, 5'd19, 5'd0,  5'd16, 1'b0, 16'h0000},
    {1'b0, 5'd20, 5'd15, 5'd6,  1'b0, 16'h0008}
  };

  string LBL [NPROG] = '{
    "R8 R10", "R2 R10", "R3 R10", "R3 R4", "R3 R5 R11",
    "R3 R6", "R9 R11", "R2", "R2", "R2",
    "R8", "R7 R12", "R2", "R2", "R2",
    "R2", "R4 R6 R7", "R2", "R2", "R8 R4",
    "R6 R11"
  };

  int  n_chk = 0;
  int  n_err = 0;
  bit  done  = 1'b0;
  logic [DW-1:0] arch [NR];

  task automatic check(input string req, input string what,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic wen, input logic [AW-1:0] dst,
                       input logic [AW-1:0] sl, input logic [AW-1:0] sr,
                       input logic ui, input logic [IW-1:0] imm);
    iss_wen = wen; iss_dst = dst; iss_src_l = sl; iss_src_r = sr;
    iss_use_imm = ui; iss_imm = imm;
  endtask

  function automatic logic [DW-1:0] rd(input logic [AW-1:0] r);
    return (r == '0) ? '0 : arch[r];
  endfunction

  initial begin
    logic [DW-1:0] exp_l, exp_r, exp_a;
    string lbl;
    drive(1'b0, '0, '0, '0, 1'b0, '0);
    for (int i = 0; i < NR; i++) begin
      rf_mem[i] = (i == 0) ? 32'hDEAD_BEEF : 32'h0300_0000 + i * 32'h0001_0011;
      arch[i]   = (i == 0) ? '0 : rf_mem[i];
    end
    exp_l = '0; exp_r = '0; exp_a = '0; lbl = "";

    repeat (3) @(negedge clk);
    check("R1", "alu_l in reset", alu_l, '0);
    check("R1", "alu_r in reset", alu_r, '0);
    check("R1", "dmem_addr in reset", dmem_addr, '0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    for (int k = 0; k <= NPROG; k++) begin
      if (k > 0) begin
        check(lbl, "alu_l", alu_l, exp_l);
        check(lbl, "alu_r", alu_r, exp_r);
        check(lbl, "dmem_addr", dmem_addr, exp_a);
      end
      if (k < NPROG) begin
        logic [32:0] w;
        logic [DW-1:0] lv, rv;
        w = PROG[k];
        drive(w[32], w[31:27], w[26:22], w[21:17], w[16], w[15:0]);
        lv = rd(w[26:22]);
        rv = w[16] ? {16'h0, w[15:0]} : rd(w[21:17]);
        exp_l = lv;
        exp_r = rv;
        exp_a = lv + {{16{w[15]}}, w[15:0]};
        lbl = LBL[k];
        if (w[32] && w[31:27] != '0) arch[w[31:27]] = lv | rv;
      end else begin
        drive(1'b0, '0, '0, '0, 1'b0, '0);
      end
      @(negedge clk);
    end

    repeat (5) @(negedge clk);

    // Asynchronous clear in the middle of a run
    drive(1'b0, 5'd22, 5'd1, 5'd2, 1'b0, 16'h0100);
    @(negedge clk);
    check("R2", "alu_l before reset", alu_l, arch[1]);
    drive(1'b0, '0, '0, '0, 1'b0, '0);
    rst_n = 1'b0;
    #1;
    check("R1", "alu_l async clear", alu_l, '0);
    check("R1", "alu_r async clear", alu_r, '0);
    check("R1", "dmem_addr async clear", dmem_addr, '0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    drive(1'b1, 5'd23, 5'd3, 5'd4, 1'b0, 16'hFFFF);
    @(negedge clk);
    check("R1 R6", "alu_l after reset", alu_l, arch[3]);
    check("R1 R6", "alu_r after reset", alu_r, arch[4]);
    check("R11", "dmem_addr negative offset", dmem_addr, arch[3] - 32'd1);
    drive(1'b0, '0, '0, '0, 1'b0, '0);
    @(negedge clk);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL R2 watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

endmodule